// File: doc/BRIEF.md
# Branch Target and Link Unit

This unit resolves one branch per issue for a processor with 32-bit, word-aligned instructions. Given the address of the branch, a target-source selector, a signed displacement, the current link, count and condition registers, a condition code, a count-decrement option and a link flag, it produces the next fetch address. It also decides whether the branch is taken, and it issues write enables with new values for the link and count registers. The register files themselves live outside the block: the unit only reads their present values and proposes updates.

The target can come from four sources: the branch address plus the displacement, the displacement alone (absolute), the link register, or the count register. In every case the two low address bits are cleared. Conditions test one bit of a selected 4-bit condition-register field, either true or complemented, or always pass. An independent decrement option reduces the count register by one and additionally requires the new count to be zero, or nonzero. Results are registered and appear on the cycle after the issue strobe.

Top module: `brTargetUnit`

## Requirements
- R1: With `targetSrc` = 2'b00 (relative), `target` equals `instAddr` plus `disp` sign-extended to the address width, modulo 2^ADDR_W, with bits [1:0] forced to zero.
- R2: With `targetSrc` = 2'b01 (absolute), `target` equals `disp` sign-extended to the address width, with bits [1:0] forced to zero.
- R3: With `targetSrc` = 2'b10, `target` is `lrIn` with bits [1:0] cleared. With `targetSrc` = 2'b11, it is `ctrIn` with bits [1:0] cleared.
- R4: A branch issued with `issueValid` high in one cycle yields `resValid` high on the next rising edge, together with all other results. When no branch was issued, and during reset, every output is zero.
- R5: Condition-register field k occupies `crIn` bits [4*(CR_FIELDS-1-k)+3 : 4*(CR_FIELDS-1-k)], holding LT, GT, EQ, SO from the most significant bit down. `condCode` values 0 to 3 pass when the LT, GT, EQ or SO bit of field `fieldSel` is 1. Values 4 to 7 pass when the same bit, selected by `condCode`[1:0], is 0 (greater-or-equal, less-or-equal, not-equal, not-summary-overflow).
- R6: `condCode` = 8 always passes, whatever the condition register holds.
- R7: With `linkFlag` set and a legal code, `lrWe` is 1 and `lrNew` = `instAddr` + 4 modulo 2^ADDR_W, whether or not the branch is taken.
- R8: A branch whose target comes from the link register and that also links takes the old `lrIn` value as its target and writes the return address as `lrNew`.
- R9: With `decEn` set and a legal code, `ctrWe` is 1 and `ctrNew` = `ctrIn` − 1 modulo 2^ADDR_W. The branch is taken only if the condition passes and the new count is zero (`decOnZero` = 1) or nonzero (`decOnZero` = 0). Without `decEn`, the count does not gate the branch and `ctrWe` stays 0.
- R10: `condCode` values 9 to 15 are reserved. Such a branch is not taken and asserts neither `lrWe` nor `ctrWe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | A branch is presented this cycle |
| instAddr | input | ADDR_W | Address of the branch instruction |
| targetSrc | input | 2 | 00 relative, 01 absolute, 10 link register, 11 count register |
| disp | input | DISP_W | Signed byte displacement |
| condCode | input | 4 | Branch condition code (0–7 field tests, 8 always, 9–15 reserved) |
| fieldSel | input | FSEL_W | Condition-register field under test |
| decEn | input | 1 | Decrement the count register |
| decOnZero | input | 1 | With decEn: 1 requires the new count to be zero, 0 requires it to be nonzero |
| linkFlag | input | 1 | Write the return address into the link register |
| crIn | input | 4*CR_FIELDS | Current condition register |
| lrIn | input | ADDR_W | Current link register |
| ctrIn | input | ADDR_W | Current count register |
| resValid | output | 1 | Results of the previous cycle's branch are valid |
| taken | output | 1 | Branch is taken |
| target | output | ADDR_W | Word-aligned target address |
| lrWe | output | 1 | Link register write enable |
| lrNew | output | ADDR_W | New link register value |
| ctrWe | output | 1 | Count register write enable |
| ctrNew | output | ADDR_W | New count register value |

## Verification
The bench builds the unit with a 32-bit address, a 16-bit displacement and eight condition fields. The narrow displacement puts the sign-extension edge at an easily chosen value, so 0x7FFF and 0x8002 show positive and negative extension directly. The full 32-bit address makes the return-address wrap at 0xFFFFFFFC and the count wrap from 0 to all-ones reachable. With eight fields, every code can be tried against first, middle and last fields, which exposes any field ordering or bit ordering error.

// File: rtl/brUnitPkg.sv
package brUnitPkg;

  typedef enum logic [1:0] {
    SRC_REL   = 2'b00,
    SRC_ABS   = 2'b01,
    SRC_LINK  = 2'b10,
    SRC_COUNT = 2'b11
  } tgtSrcE;

  // control -> datapath strobes
  typedef struct packed {
    tgtSrcE sel;
    logic   decCtr;
    logic   writeLink;
    logic   takeBranch;
  } brStrobeT;

  localparam logic [3:0] CODE_ALWAYS = 4'd8;

endpackage

// File: rtl/brDatapath.sv
module brDatapath
  import brUnitPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  tgtSrcE            sel,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] lrIn,
  input  logic [ADDR_W-1:0] ctrIn,
  output logic [ADDR_W-1:0] targetAddr,
  output logic [ADDR_W-1:0] returnAddr,
  output logic [ADDR_W-1:0] ctrDecr,
  output logic              ctrZeroAfter
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] relSum;
  logic [ADDR_W-1:0] rawTarget;

  assign dispExt = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign relSum  = instAddr + dispExt;

  always_comb begin
    unique case (sel)
      SRC_REL:   rawTarget = relSum;
      SRC_ABS:   rawTarget = dispExt;
      SRC_LINK:  rawTarget = lrIn;
      SRC_COUNT: rawTarget = ctrIn;
      default:   rawTarget = relSum;
    endcase
  end

  // word alignment of every target
  assign targetAddr   = {rawTarget[ADDR_W-1:2], 2'b00};
  assign returnAddr   = instAddr + ADDR_W'(4);
  assign ctrDecr      = ctrIn - ADDR_W'(1);
  assign ctrZeroAfter = (ctrDecr == '0);

  // R9
  ctr_zero_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrZeroAfter |-> (ctrIn == ADDR_W'(1)));

endmodule

// File: rtl/brControl.sv
module brControl
  import brUnitPkg::*;
#(
  parameter int CR_FIELDS = 8,
  parameter int FSEL_W    = (CR_FIELDS > 1) ? $clog2(CR_FIELDS) : 1,
  parameter int CR_W      = 4 * CR_FIELDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [1:0]        targetSrc,
  input  logic [3:0]        condCode,
  input  logic [FSEL_W-1:0] fieldSel,
  input  logic              decEn,
  input  logic              decOnZero,
  input  logic              linkFlag,
  input  logic [CR_W-1:0]   crIn,
  input  logic              ctrZeroAfter,
  output brStrobeT          strobe
);

  // fieldBits[k][3:0] = LT, GT, EQ, SO; field 0 sits at the top of crIn
  logic [3:0] fieldBits [CR_FIELDS];

  for (genvar g = 0; g < CR_FIELDS; g++) begin : g_field
    assign fieldBits[g] = crIn[CR_W-1-4*g -: 4];
  end

  logic [3:0] selField;
  logic       testBit;
  logic       codeLegal;
  logic       condOk;
  logic       ctrOk;

  assign selField  = fieldBits[fieldSel];
  assign codeLegal = (condCode <= CODE_ALWAYS);

  always_comb begin
    unique case (condCode[1:0])
      2'd0:    testBit = selField[3];
      2'd1:    testBit = selField[2];
      2'd2:    testBit = selField[1];
      default: testBit = selField[0];
    endcase
  end

  always_comb begin
    if (condCode == CODE_ALWAYS) condOk = 1'b1;
    else if (condCode[3])        condOk = 1'b0;
    else if (condCode[2])        condOk = ~testBit;
    else                         condOk = testBit;
  end

  always_comb begin
    if (!decEn)        ctrOk = 1'b1;
    else if (decOnZero) ctrOk = ctrZeroAfter;
    else               ctrOk = ~ctrZeroAfter;
  end

  always_comb begin
    strobe.sel        = tgtSrcE'(targetSrc);
    strobe.decCtr     = issueValid & codeLegal & decEn;
    strobe.writeLink  = issueValid & codeLegal & linkFlag;
    strobe.takeBranch = issueValid & codeLegal & condOk & ctrOk;
  end

  // R10
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && condCode > CODE_ALWAYS) |->
      (!strobe.takeBranch && !strobe.decCtr && !strobe.writeLink));

  // R6
  always_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && condCode == CODE_ALWAYS && !decEn) |-> strobe.takeBranch);

endmodule

// File: rtl/brTargetUnit.sv
module brTargetUnit
  import brUnitPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DISP_W    = 24,
  parameter int CR_FIELDS = 8,
  parameter int FSEL_W    = (CR_FIELDS > 1) ? $clog2(CR_FIELDS) : 1,
  parameter int CR_W      = 4 * CR_FIELDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [1:0]        targetSrc,
  input  logic [DISP_W-1:0] disp,
  input  logic [3:0]        condCode,
  input  logic [FSEL_W-1:0] fieldSel,
  input  logic              decEn,
  input  logic              decOnZero,
  input  logic              linkFlag,
  input  logic [CR_W-1:0]   crIn,
  input  logic [ADDR_W-1:0] lrIn,
  input  logic [ADDR_W-1:0] ctrIn,
  output logic              resValid,
  output logic              taken,
  output logic [ADDR_W-1:0] target,
  output logic              lrWe,
  output logic [ADDR_W-1:0] lrNew,
  output logic              ctrWe,
  output logic [ADDR_W-1:0] ctrNew
);

  brStrobeT          strobe;
  logic [ADDR_W-1:0] targetAddr;
  logic [ADDR_W-1:0] returnAddr;
  logic [ADDR_W-1:0] ctrDecr;
  logic              ctrZeroAfter;

  brControl #(
    .CR_FIELDS (CR_FIELDS),
    .FSEL_W    (FSEL_W),
    .CR_W      (CR_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .issueValid   (issueValid),
    .targetSrc    (targetSrc),
    .condCode     (condCode),
    .fieldSel     (fieldSel),
    .decEn        (decEn),
    .decOnZero    (decOnZero),
    .linkFlag     (linkFlag),
    .crIn         (crIn),
    .ctrZeroAfter (ctrZeroAfter),
    .strobe       (strobe)
  );

  brDatapath #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .sel          (strobe.sel),
    .instAddr     (instAddr),
    .disp         (disp),
    .lrIn         (lrIn),
    .ctrIn        (ctrIn),
    .targetAddr   (targetAddr),
    .returnAddr   (returnAddr),
    .ctrDecr      (ctrDecr),
    .ctrZeroAfter (ctrZeroAfter)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      taken    <= 1'b0;
      target   <= '0;
      lrWe     <= 1'b0;
      lrNew    <= '0;
      ctrWe    <= 1'b0;
      ctrNew   <= '0;
    end else begin
      resValid <= issueValid;
      taken    <= strobe.takeBranch;
      target   <= issueValid ? targetAddr : '0;
      lrWe     <= strobe.writeLink;
      lrNew    <= strobe.writeLink ? returnAddr : '0;
      ctrWe    <= strobe.decCtr;
      ctrNew   <= strobe.decCtr ? ctrDecr : '0;
    end
  end

  // R4
  result_follows_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid || taken || lrWe || ctrWe) |-> $past(issueValid));

  // R1
  target_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (target[1:0] == 2'b00));

  // R7
  lr_new_chk: assert property (@(posedge clk) disable iff (!rstN)
    lrWe |-> (lrNew == $past(instAddr) + ADDR_W'(4)));

  // R9
  ctr_new_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrWe |-> (ctrNew == $past(ctrIn) - ADDR_W'(1)));

  // R8
  old_link_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && $past(targetSrc) == 2'b10) |->
      (target[ADDR_W-1:2] == $past(lrIn[ADDR_W-1:2])));

  // R9
  dec_zero_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && $past(decEn) && $past(decOnZero)) |-> (ctrNew == '0));

endmodule

// File: tb/brTargetUnit_bench.sv
module brTargetUnit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int DISP_W     = 16;
  localparam int CR_FIELDS  = 8;
  localparam int FSEL_W     = 3;
  localparam int CR_W       = 4 * CR_FIELDS;

  logic              clk = 1'b0;
  logic              rstN;
  logic              issueValid;
  logic [ADDR_W-1:0] instAddr;
  logic [1:0]        targetSrc;
  logic [DISP_W-1:0] disp;
  logic [3:0]        condCode;
  logic [FSEL_W-1:0] fieldSel;
  logic              decEn;
  logic              decOnZero;
  logic              linkFlag;
  logic [CR_W-1:0]   crIn;
  logic [ADDR_W-1:0] lrIn;
  logic [ADDR_W-1:0] ctrIn;
  logic              resValid;
  logic              taken;
  logic [ADDR_W-1:0] target;
  logic              lrWe;
  logic [ADDR_W-1:0] lrNew;
  logic              ctrWe;
  logic [ADDR_W-1:0] ctrNew;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brTargetUnit #(
    .ADDR_W    (ADDR_W),
    .DISP_W    (DISP_W),
    .CR_FIELDS (CR_FIELDS)
  ) u_brTargetUnit (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .instAddr   (instAddr),
    .targetSrc  (targetSrc),
    .disp       (disp),
    .condCode   (condCode),
    .fieldSel   (fieldSel),
    .decEn      (decEn),
    .decOnZero  (decOnZero),
    .linkFlag   (linkFlag),
    .crIn       (crIn),
    .lrIn       (lrIn),
    .ctrIn      (ctrIn),
    .resValid   (resValid),
    .taken      (taken),
    .target     (target),
    .lrWe       (lrWe),
    .lrNew      (lrNew),
    .ctrWe      (ctrWe),
    .ctrNew     (ctrNew)
  );

  task automatic check(input string req, input string what,
                       input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic clearInputs();
    issueValid = 1'b0; instAddr = '0; targetSrc = 2'b00; disp = '0;
    condCode = 4'd8; fieldSel = '0; decEn = 1'b0; decOnZero = 1'b0;
    linkFlag = 1'b0; crIn = '0; lrIn = '0; ctrIn = '0;
  endtask

  // Issue one branch (called at a falling edge) and compare against the
  // values computed here from the requirements.
  task automatic runBranch(input string req,
                           input logic [ADDR_W-1:0] pc, input logic [1:0] src,
                           input logic [DISP_W-1:0] d, input logic [3:0] code,
                           input logic [FSEL_W-1:0] fld, input logic dEn,
                           input logic dZero, input logic lnk,
                           input logic [CR_W-1:0] cr, input logic [ADDR_W-1:0] lr,
                           input logic [ADDR_W-1:0] ctr);
    logic [ADDR_W-1:0] expTgt, sx, expCtr;
    logic expTaken, expLrWe, expCtrWe, legal, cond, bitVal, ctrPass;
    int bitPos;
    issueValid = 1'b1; instAddr = pc; targetSrc = src; disp = d;
    condCode = code; fieldSel = fld; decEn = dEn; decOnZero = dZero;
    linkFlag = lnk; crIn = cr; lrIn = lr; ctrIn = ctr;

    sx = ADDR_W'(signed'(d));
    case (src)
      2'b00:   expTgt = pc + sx;
      2'b01:   expTgt = sx;
      2'b10:   expTgt = lr;
      default: expTgt = ctr;
    endcase
    expTgt = expTgt & ~ADDR_W'(3);
    legal  = (code <= 4'd8);
    bitPos = CR_W - 1 - 4 * int'(fld) - int'(code[1:0]);
    bitVal = cr[bitPos];
    if (code == 4'd8)      cond = 1'b1;
    else if (code < 4'd4)  cond = bitVal;
    else if (code < 4'd8)  cond = !bitVal;
    else                   cond = 1'b0;
    expCtr   = ctr - 1;
    ctrPass  = !dEn || (dZero ? (expCtr == 0) : (expCtr != 0));
    expTaken = legal && cond && ctrPass;
    expLrWe  = legal && lnk;
    expCtrWe = legal && dEn;

    @(posedge clk);
    @(negedge clk);
    check(req, "resValid", ADDR_W'(resValid), 1);
    check(req, "taken",    ADDR_W'(taken),    ADDR_W'(expTaken));
    check(req, "target",   target,            expTgt);
    check(req, "lrWe",     ADDR_W'(lrWe),     ADDR_W'(expLrWe));
    if (expLrWe)  check(req, "lrNew",  lrNew,  pc + 4);
    check(req, "ctrWe",    ADDR_W'(ctrWe),    ADDR_W'(expCtrWe));
    if (expCtrWe) check(req, "ctrNew", ctrNew, expCtr);
    issueValid = 1'b0;
  endtask

  task automatic checkIdle(input string req);
    check(req, "idle resValid", ADDR_W'(resValid), 0);
    check(req, "idle taken",    ADDR_W'(taken),    0);
    check(req, "idle target",   target,            0);
    check(req, "idle lrWe",     ADDR_W'(lrWe),     0);
    check(req, "idle ctrWe",    ADDR_W'(ctrWe),    0);
  endtask

  task automatic testReset();   // R4
    clearInputs();
    rstN = 1'b0;
    issueValid = 1'b1;
    repeat (3) @(negedge clk);
    checkIdle("R4");
    issueValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R4");
  endtask

  task automatic testRelative(); // R1
    runBranch("R1", 32'h0000_1000, 2'b00, 16'h0104, 4'd8, 0, 0, 0, 0, '0, '0, '0);
    runBranch("R1", 32'h0000_1000, 2'b00, 16'hFFF3, 4'd8, 0, 0, 0, 0, '0, '0, '0);
    runBranch("R1", 32'hFFFF_FFF0, 2'b00, 16'h0020, 4'd8, 0, 0, 0, 0, '0, '0, '0);
    @(negedge clk);
    checkIdle("R4");
  endtask

  task automatic testAbsolute(); // R2
    runBranch("R2", 32'h1234_5678, 2'b01, 16'h7FFF, 4'd8, 0, 0, 0, 0, '0, '0, '0);
    runBranch("R2", 32'h1234_5678, 2'b01, 16'h8002, 4'd8, 0, 0, 0, 0, '0, '0, '0);
  endtask

  task automatic testRegSources(); // R3
    runBranch("R3", 32'h0000_0100, 2'b10, 16'h0040, 4'd8, 0, 0, 0, 0, '0, 32'h0000_2003, 32'h0000_9999);
    runBranch("R3", 32'h0000_0100, 2'b11, 16'h0040, 4'd8, 0, 0, 0, 0, '0, 32'h0000_2003, 32'h0000_ABCD);
  endtask

  task automatic testConditions(); // R5
    logic [CR_W-1:0] pats [4];
    pats[0] = 32'h8421_8421;
    pats[1] = 32'h7BDE_7BDE;
    pats[2] = 32'hF00F_0A50;
    pats[3] = 32'h0000_0001;
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 8; c++) begin
        for (int f = 0; f < CR_FIELDS; f += 3) begin
          runBranch("R5", 32'h0000_4000, 2'b00, 16'h0010, 4'(c), FSEL_W'(f),
                    0, 0, 0, pats[p], '0, '0);
        end
        runBranch("R5", 32'h0000_4000, 2'b00, 16'h0010, 4'(c), 3'd7,
                  0, 0, 0, pats[p], '0, '0);
      end
    end
  endtask

  task automatic testAlways(); // R6
    runBranch("R6", 32'h0000_0200, 2'b00, 16'h0008, 4'd8, 3'd5, 0, 0, 0, '0, '0, '0);
    runBranch("R6", 32'h0000_0200, 2'b00, 16'h0008, 4'd8, 3'd2, 0, 0, 0, '1, '0, '0);
  endtask

  task automatic testLink(); // R7
    // not-taken branch still links
    runBranch("R7", 32'h0000_3000, 2'b00, 16'h0100, 4'd0, 3'd0, 0, 0, 1, '0, '0, '0);
    // return address wraps
    runBranch("R7", 32'hFFFF_FFFC, 2'b00, 16'h0100, 4'd8, 3'd0, 0, 0, 1, '0, '0, '0);
  endtask

  task automatic testLinkOld(); // R8
    runBranch("R8", 32'h0000_0800, 2'b10, 16'h0000, 4'd8, 3'd0, 0, 0, 1, '0, 32'h0000_0400, '0);
    runBranch("R8", 32'h0000_0800, 2'b10, 16'h0000, 4'd8, 3'd0, 0, 0, 1, '0, 32'h0000_0806, '0);
  endtask

  task automatic testDecrement(); // R9
    runBranch("R9", 32'h0000_5000, 2'b00, 16'h0040, 4'd8, 0, 1, 1, 0, '0, '0, 32'd1);
    runBranch("R9", 32'h0000_5000, 2'b00, 16'h0040, 4'd8, 0, 1, 1, 0, '0, '0, 32'd2);
    runBranch("R9", 32'h0000_5000, 2'b00, 16'h0040, 4'd8, 0, 1, 0, 0, '0, '0, 32'd2);
    runBranch("R9", 32'h0000_5000, 2'b00, 16'h0040, 4'd8, 0, 1, 0, 0, '0, '0, 32'd1);
    runBranch("R9", 32'h0000_5000, 2'b00, 16'h0040, 4'd8, 0, 1, 0, 0, '0, '0, 32'd0);
    // condition fails while count passes: not taken, count still written
    runBranch("R9", 32'h0000_5000, 2'b00, 16'h0040, 4'd2, 3'd1, 1, 0, 0, '0, '0, 32'd9);
    // condition passes, count fails
    runBranch("R9", 32'h0000_5000, 2'b00, 16'h0040, 4'd6, 3'd1, 1, 1, 0, '0, '0, 32'd9);
    // count register as target uses the old count
    runBranch("R9", 32'h0000_5000, 2'b11, 16'h0040, 4'd8, 0, 1, 0, 1, '0, '0, 32'h0000_7008);
  endtask

  task automatic testReserved(); // R10
    for (int c = 9; c < 16; c++) begin
      runBranch("R10", 32'h0000_6000, 2'b00, 16'h0010, 4'(c), 3'd0, 1, 1, 1, '1, '0, 32'd1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clearInputs();
    rstN = 1'b0;
    @(negedge clk);
    testReset();
    testRelative();
    testAbsolute();
    testRegSources();
    testConditions();
    testAlways();
    testLink();
    testLinkOld();
    testDecrement();
    testReserved();
    @(negedge clk);
    checkIdle("R4");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule